// File: doc/BRIEF.md
# Cache Miss Replay Logger

This block sits next to one core's data cache and writes a per-thread log from which that thread's execution can be replayed on its own. It counts every memory operation the core retires. It writes a record only when an operation misses in the cache, and that record pairs the operation count with the data word the fill brought in. Hits leave no trace. Coherence traffic is never seen or logged, because a line stolen by a remote write simply shows up later as an ordinary miss.

A log opens with a checkpoint: one record with the program counter, then one record per architectural register, in ascending register index. A checkpoint is taken automatically after reset and again whenever the core pulses a request. Records leave on a valid/ready stream. The stream rules are as follows. A record, once valid, stays valid and unchanged until ready is seen high at a clock edge. When the single output slot cannot drain, the block raises a stall toward the core and accepts no further operations. The stall is also high for the whole of a checkpoint. A core must hold an operation that it presents while the stall is high; the logger neither counts nor logs such an operation.

Top module: `miss_replay_logger`

## Requirements
- R1: While reset is held and on the first cycle after it, `rec_valid` is 0 and `stall` is 1. The first records the block sends are a checkpoint.
- R2: A checkpoint is NUM_REGS+1 records with `rec_type`=1. The PC word comes first, then register 0, 1, ... NUM_REGS-1. Each `rec_count` equals the memory count at the moment of capture.
- R3: Every accepted operation (`mem_op_valid`=1 while `stall`=0) adds one to the memory count, whether it hits or misses.
- R4: An accepted miss produces a record with `rec_type`=0, `rec_count` equal to the count that includes this operation (so the first operation after reset is 1), and `rec_data` equal to `mem_fill_data`.
- R5: An accepted hit produces no record.
- R6: Misses from any cause (load, store, or a line lost to a remote write) are logged the same way. For a store miss, `mem_fill_data` carries the word as it was before the store merged, and that word is what gets logged.
- R7: While `rec_valid`=1 and `rec_ready`=0, the record stays stable and `stall`=1. Each record is delivered exactly once.
- R8: An operation presented while `stall`=1 is neither counted nor logged.
- R9: When the block is idle, a `ckpt_req` pulse starts a checkpoint of the `pc_in`/`regs_in` values present one cycle later. A pulse that arrives while a checkpoint is pending or running is ignored.
- R10: The memory count is CNT_W bits wide and wraps to 0 without any signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckpt_req | input | 1 | One-cycle request for a new checkpoint |
| pc_in | input | DATA_W | Current program counter |
| regs_in | input | NUM_REGS*DATA_W | Register values, register i at bits [i*DATA_W +: DATA_W] |
| mem_op_valid | input | 1 | A retired memory operation is presented |
| mem_op_hit | input | 1 | 1 = cache hit, 0 = miss |
| mem_fill_data | input | DATA_W | Word fetched on a miss (the pre-store value for a store miss) |
| stall | output | 1 | Core must hold its memory operation |
| rec_valid | output | 1 | Output record valid |
| rec_ready | input | 1 | Log sink accepts the record |
| rec_type | output | 1 | 1 = checkpoint record, 0 = miss record |
| rec_count | output | CNT_W | Memory count carried by the record |
| rec_data | output | DATA_W | PC, register value or fill word |

## Verification
A table drives a stream of hits, misses and idle cycles with the sink always ready. The test checks that only misses appear, in order, with the correct running count. A second copy of the block with a 4-bit counter sees the same stream, which shows that the count wraps. Directed tests follow. One holds the sink not-ready while the core keeps offering a different miss, which separates a correct hold from an overwrite and from a counted blocked operation. Another requests a checkpoint mid-stream and then requests again while it runs, which shows the captured PC and register order and that the second request is ignored.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic {
    REC_MISS = 1'b0,
    REC_CKPT = 1'b1
  } rec_kind_e;
endpackage

// File: rtl/mrl_op_counter.sv
module mrl_op_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else if (inc_i) count_o <= count_o + CNT_W'(1);
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> count_o == $past(count_o) + CNT_W'(1));
  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(count_o));
endmodule

// File: rtl/mrl_ckpt_seq.sv
module mrl_ckpt_seq #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [DATA_W-1:0]          pc_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic                       take_i,
  output logic                       busy_o,
  output logic                       word_valid_o,
  output logic [DATA_W-1:0]          word_o
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS);

  logic              arm_q, active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] snap_pc_q;
  logic [DATA_W-1:0] snap_reg_q [NUM_REGS];
  logic [DATA_W-1:0] reg_in    [NUM_REGS];
  logic [SEL_W-1:0]  reg_sel;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign reg_in[g] = regs_i[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q    <= 1'b1;
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (arm_q && !active_q) begin
      arm_q    <= 1'b0;
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && take_i) begin
      if (idx_q == LAST) active_q <= 1'b0;
      idx_q <= idx_q + IDX_W'(1);
    end else if (req_i && !active_q) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (arm_q && !active_q) begin
      snap_pc_q <= pc_i;
      for (int i = 0; i < NUM_REGS; i++) snap_reg_q[i] <= reg_in[i];
    end
  end

  assign reg_sel      = SEL_W'(idx_q - IDX_W'(1));
  assign busy_o       = arm_q | active_q;
  assign word_valid_o = active_q;
  assign word_o       = (idx_q == '0) ? snap_pc_q : snap_reg_q[reg_sel];

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> idx_q <= LAST);
  // R2
  ckpt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && take_i && idx_q != LAST) |=> (active_q && idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/mrl_record_slot.sv
module mrl_record_slot #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              type_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic              type_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      type_o  <= 1'b0;
      count_o <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      type_o  <= type_i;
      count_o <= count_i;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign free_o = !valid_o || ready_i;

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(count_o) && $stable(type_o)));
endmodule

// File: rtl/miss_replay_logger.sv
module miss_replay_logger #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ckpt_req,
  input  logic [DATA_W-1:0]          pc_in,
  input  logic [NUM_REGS*DATA_W-1:0] regs_in,
  input  logic                       mem_op_valid,
  input  logic                       mem_op_hit,
  input  logic [DATA_W-1:0]          mem_fill_data,
  output logic                       stall,
  output logic                       rec_valid,
  input  logic                       rec_ready,
  output logic                       rec_type,
  output logic [CNT_W-1:0]           rec_count,
  output logic [DATA_W-1:0]          rec_data
);
  import mrl_pkg::*;

  logic              slot_free, ckpt_busy, ckpt_wvalid;
  logic [DATA_W-1:0] ckpt_word;
  logic [CNT_W-1:0]  mem_count;
  logic              op_accept, log_miss, ckpt_take, slot_load, slot_type;
  logic [CNT_W-1:0]  slot_count;
  logic [DATA_W-1:0] slot_data;

  assign stall     = !slot_free || ckpt_busy;
  assign op_accept = mem_op_valid && !stall;
  assign log_miss  = op_accept && !mem_op_hit;
  assign ckpt_take = ckpt_wvalid && slot_free && !log_miss;
  assign slot_load = log_miss || ckpt_take;

  always_comb begin
    if (log_miss) begin
      slot_type  = REC_MISS;
      slot_count = mem_count + CNT_W'(1);
      slot_data  = mem_fill_data;
    end else begin
      slot_type  = REC_CKPT;
      slot_count = mem_count;
      slot_data  = ckpt_word;
    end
  end

  mrl_op_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc_i(op_accept), .count_o(mem_count)
  );

  mrl_ckpt_seq #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_ckpt (
    .clk(clk), .rst_n(rst_n), .req_i(ckpt_req), .pc_i(pc_in), .regs_i(regs_in),
    .take_i(ckpt_take), .busy_o(ckpt_busy), .word_valid_o(ckpt_wvalid), .word_o(ckpt_word)
  );

  mrl_record_slot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_i(slot_load), .type_i(slot_type),
    .count_i(slot_count), .data_i(slot_data), .ready_i(rec_ready),
    .free_o(slot_free), .valid_o(rec_valid), .type_o(rec_type),
    .count_o(rec_count), .data_o(rec_data)
  );

  // R7
  stall_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |-> stall);
  // R4
  miss_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_miss |=> (rec_valid && rec_type == REC_MISS && rec_data == $past(mem_fill_data)));
  // R5
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_op_valid && mem_op_hit && !stall && !ckpt_wvalid) |=> !rec_valid);
  // R8
  blocked_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_op_valid && stall) |=> $stable(mem_count));
endmodule

// File: tb/miss_replay_logger_bench.sv
module miss_replay_logger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 4;
  localparam int NV = 22;
  // {valid, hit, fill data}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h1000_0001}, {1'b1, 1'b1, 32'hFFFF_0000},
    {1'b1, 1'b0, 32'h1000_0003}, {1'b0, 1'b0, 32'hEEEE_0000},
    {1'b1, 1'b1, 32'hFFFF_0001}, {1'b1, 1'b1, 32'hFFFF_0002},
    {1'b1, 1'b0, 32'h1000_0007}, {1'b1, 1'b0, 32'h1000_0008},
    {1'b1, 1'b0, 32'h1000_0009}, {1'b0, 1'b1, 32'hEEEE_0001},
    {1'b1, 1'b1, 32'hFFFF_0003}, {1'b1, 1'b0, 32'h1000_000C},
    {1'b1, 1'b1, 32'hFFFF_0004}, {1'b1, 1'b0, 32'h1000_000E},
    {1'b1, 1'b1, 32'hFFFF_0005}, {1'b1, 1'b1, 32'hFFFF_0006},
    {1'b1, 1'b0, 32'h1000_0011}, {1'b1, 1'b0, 32'h1000_0012},
    {1'b0, 1'b0, 32'hEEEE_0002}, {1'b1, 1'b0, 32'h1000_0014},
    {1'b1, 1'b1, 32'hFFFF_0007}, {1'b1, 1'b0, 32'h1000_0016}
  };

  logic clk = 0, rst_n = 0, ckpt_req = 0, rec_ready = 1;
  logic [DW-1:0] pc_in = 32'h0000_1000;
  logic [NR*DW-1:0] regs_in;
  logic mem_op_valid = 0, mem_op_hit = 0;
  logic [DW-1:0] mem_fill_data = '0;
  logic stall, rec_valid, rec_type;
  logic [31:0] rec_count;
  logic [DW-1:0] rec_data;
  logic s_stall, s_valid, s_type;
  logic [3:0] s_count;
  logic [DW-1:0] s_data;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] cap_cnt [64];
  logic [DW-1:0] cap_data [64];
  logic cap_type [64];
  int cap_n = 0;
  logic [3:0] cs_cnt [64];
  int cs_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_replay_logger #(.DATA_W(DW), .CNT_W(32), .NUM_REGS(NR)) u_miss_replay_logger (
    .clk(clk), .rst_n(rst_n), .ckpt_req(ckpt_req), .pc_in(pc_in), .regs_in(regs_in),
    .mem_op_valid(mem_op_valid), .mem_op_hit(mem_op_hit), .mem_fill_data(mem_fill_data),
    .stall(stall), .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type),
    .rec_count(rec_count), .rec_data(rec_data));

  miss_replay_logger #(.DATA_W(DW), .CNT_W(4), .NUM_REGS(NR)) u_small (
    .clk(clk), .rst_n(rst_n), .ckpt_req(ckpt_req), .pc_in(pc_in), .regs_in(regs_in),
    .mem_op_valid(mem_op_valid), .mem_op_hit(mem_op_hit), .mem_fill_data(mem_fill_data),
    .stall(s_stall), .rec_valid(s_valid), .rec_ready(rec_ready), .rec_type(s_type),
    .rec_count(s_count), .rec_data(s_data));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && rec_valid && rec_ready && cap_n < 64) begin
      cap_cnt[cap_n] <= rec_count; cap_data[cap_n] <= rec_data;
      cap_type[cap_n] <= rec_type; cap_n <= cap_n + 1;
    end
    if (rst_n && s_valid && rec_ready && cs_n < 64) begin
      cs_cnt[cs_n] <= s_count; cs_n <= cs_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_regs(input logic [31:0] base);
    for (int i = 0; i < NR; i++) regs_in[i*DW +: DW] = base + 32'(i);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    while (cycles < 5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<5000", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp_cnt, base, nrec, c0;
    set_regs(32'h0000_00A0);
    step(3);
    // R1 reset state
    chk(rec_valid == 1'b0, "R1", 64'(rec_valid), 0);
    chk(stall == 1'b1, "R1", 64'(stall), 1);
    rst_n = 1;
    step(1);
    chk(rec_valid == 1'b0 && stall == 1'b1, "R1", {62'b0, rec_valid, stall}, 1);
    step(8);
    // R2 start-up checkpoint
    chk(cap_n == NR + 1, "R2", 64'(cap_n), 64'(NR + 1));
    chk(cap_type[0] == 1'b1 && cap_data[0] == 32'h0000_1000 && cap_cnt[0] == 0, "R2",
        64'(cap_data[0]), 64'h1000);
    for (int i = 0; i < NR; i++)
      chk(cap_type[i+1] == 1'b1 && cap_data[i+1] == 32'h0000_00A0 + 32'(i) && cap_cnt[i+1] == 0,
          "R2", 64'(cap_data[i+1]), 64'(32'h0000_00A0 + 32'(i)));
    chk(stall == 1'b0, "R1", 64'(stall), 0);

    // table walk: R3 R4 R5 R6 R10
    base = cap_n;
    for (int v = 0; v < NV; v++) begin
      mem_op_valid = VEC[v][33]; mem_op_hit = VEC[v][32]; mem_fill_data = VEC[v][31:0];
      step(1);
    end
    mem_op_valid = 0;
    step(3);
    exp_cnt = 0; nrec = 0;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][33]) begin
        exp_cnt++;
        if (!VEC[v][32]) begin
          chk(cap_type[base+nrec] == 1'b0 && cap_data[base+nrec] == VEC[v][31:0], "R4",
              64'(cap_data[base+nrec]), 64'(VEC[v][31:0]));
          chk(cap_cnt[base+nrec] == 32'(exp_cnt), "R3", 64'(cap_cnt[base+nrec]), 64'(exp_cnt));
          chk(cs_cnt[base+nrec] == 4'(exp_cnt), "R10", 64'(cs_cnt[base+nrec]), 64'(4'(exp_cnt)));
          nrec++;
        end
      end
    end
    // R5 hits add nothing: record total equals miss total
    chk(cap_n == base + nrec, "R5", 64'(cap_n), 64'(base + nrec));

    // back-pressure: R7 R8 (store miss logs the pre-update word, R6)
    base = cap_n;
    rec_ready = 0;
    mem_op_valid = 1; mem_op_hit = 0; mem_fill_data = 32'hDEAD_0001;
    step(1);
    mem_fill_data = 32'hBAD0_BAD0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk(rec_valid && rec_data == 32'hDEAD_0001 && rec_count == 32'(exp_cnt + 1), "R7",
          64'(rec_data), 64'hDEAD_0001);
      chk(stall == 1'b1, "R7", 64'(stall), 1);
    end
    mem_op_valid = 0;
    rec_ready = 1;
    step(2);
    mem_op_valid = 1; mem_op_hit = 0; mem_fill_data = 32'h5150_0002;
    step(1);
    mem_op_valid = 0;
    step(3);
    chk(cap_n == base + 2, "R7", 64'(cap_n), 64'(base + 2));
    chk(cap_data[base] == 32'hDEAD_0001 && cap_cnt[base] == 32'(exp_cnt + 1), "R6",
        64'(cap_data[base]), 64'hDEAD_0001);
    chk(cap_data[base+1] == 32'h5150_0002 && cap_cnt[base+1] == 32'(exp_cnt + 2), "R8",
        64'(cap_cnt[base+1]), 64'(exp_cnt + 2));
    exp_cnt += 2;

    // requested checkpoint: R9
    base = cap_n;
    c0 = exp_cnt;
    pc_in = 32'h0000_2000; set_regs(32'h0000_0B00);
    ckpt_req = 1;
    step(1);
    ckpt_req = 0;
    chk(stall == 1'b1, "R9", 64'(stall), 1);
    step(1);
    pc_in = 32'h0000_3000; set_regs(32'h0000_0C00);
    ckpt_req = 1;
    step(1);
    ckpt_req = 0;
    step(12);
    chk(cap_n == base + NR + 1, "R9", 64'(cap_n), 64'(base + NR + 1));
    chk(cap_type[base] == 1'b1 && cap_data[base] == 32'h0000_2000 && cap_cnt[base] == 32'(c0),
        "R9", 64'(cap_data[base]), 64'h2000);
    for (int i = 0; i < NR; i++)
      chk(cap_data[base+1+i] == 32'h0000_0B00 + 32'(i) && cap_cnt[base+1+i] == 32'(c0), "R2",
          64'(cap_data[base+1+i]), 64'(32'h0000_0B00 + 32'(i)));
    chk(stall == 1'b0, "R9", 64'(stall), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule